// File: doc/BRIEF.md
# SPI master shift engine

This block is a single-clock SPI master that moves one 8-bit frame per start strobe. The host supplies a byte to send, a divider value, a clock polarity, a clock phase and a bit-order flag, then pulses `start`. The engine pulls the active-low select low and waits a lead interval. It then produces sixteen SCK edges with a 50% duty cycle, shifting the byte out on MOSI and collecting a byte from MISO. After the last edge it waits a lag interval, releases the select and pulses `done` with the received byte on `rx_data`.

All timing is counted in bus clocks from a half-period value `h` derived from the divider input. The lead interval, each SCK high time, each SCK low time and the lag interval are each `h` bus clocks, so a frame keeps `busy` high for exactly `(2*FRAME_W+1)*h` cycles. The configuration inputs and the transmit byte are captured when the strobe is accepted, and changes to them during a frame have no effect.

Top module: `spi_master_engine`

## Requirements
- R1: The half period is h = ceil(div/2) clamped to the range 1 to MAX_PERIOD/2 (1024 by default), so div=0 gives h=1 and div=4095 gives h=1024. Every SCK high time and every SCK low time inside a frame lasts exactly h bus clocks.
- R2: SCK rests at the level of `cpol` (0 = low, 1 = high) while no frame runs. A frame has exactly 2*FRAME_W SCK transitions, and SCK is back at the captured `cpol` level when `ss_n` rises.
- R3: The first SCK transition comes h bus clocks after `ss_n` falls. `ss_n` rises h bus clocks after the last SCK transition.
- R4: With `cpha`=0, MOSI already carries the first bit when `ss_n` falls. MISO is sampled on the 1st, 3rd, … SCK transitions, and MOSI changes only on the 2nd, 4th, … transitions.
- R5: With `cpha`=1, MOSI changes on the 1st, 3rd, … SCK transitions, which present bits 1 to FRAME_W in order. MISO is sampled on the 2nd, 4th, … transitions.
- R6: With `lsbf`=0 both directions use bit 7 first and bit 0 last. With `lsbf`=1 both use bit 0 first and bit 7 last. `rx_data` holds the received byte in its natural bit positions.
- R7: `busy` and a low `ss_n` appear in the cycle after an accepted strobe. They last (2*FRAME_W+1)*h cycles. `done` is high for exactly one cycle, the first cycle with `ss_n` high and `busy` low, and `rx_data` is valid from that cycle on.
- R8: A strobe that arrives while `busy` is high is ignored, including one in the last busy cycle. A strobe in the `done` cycle starts a new frame.
- R9: `cpol`, `cpha`, `lsbf`, `div` and `tx_data` are captured when a strobe is accepted. Changing them during a frame does not alter that frame's timing, data or bit order.
- R10: After reset `ss_n` is 1, `busy` is 0, `done` is 0 and SCK is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a frame when idle |
| tx_data | input | FRAME_W | Byte to send |
| div | input | DIV_W (12) | Bus clocks per SCK period, even, 2 to MAX_PERIOD |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | 0: sample on first edge of each bit; 1: sample on second edge |
| lsbf | input | 1 | 1: bit 0 first |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | 1 | Active-low slave select |
| rx_data | output | FRAME_W | Last received byte |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
A host start strobe can coincide with the end of a frame. The engine leaves its lag phase at the same edge where a strobe could be sampled, so a strobe in the last busy cycle must be lost, while a strobe one cycle later, in the `done` cycle, must open a new frame with no idle gap. The bench raises `start` in each of these two cycles. It judges the first case by seeing `busy` still low two cycles on. It judges the second by seeing `busy` and a low `ss_n` in the next cycle, followed by a complete and correctly timed second frame.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LEAD = 2'd1,
      PH_XFER = 2'd2,
      PH_LAG  = 2'd3
   } spi_phase_e;

endpackage

// File: rtl/spi_eng_divider.sv
module spi_eng_divider #(
   parameter int HALF_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [HALF_W-1:0] half_in,
   input  logic              run,
   output logic              tick
);

   logic [HALF_W-1:0] half_q;
   logic [HALF_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q <= {{(HALF_W-1){1'b0}}, 1'b1};
         cnt_q  <= '0;
      end else if (load) begin
         half_q <= half_in;
         cnt_q  <= half_in - 1'b1;
      end else if (run) begin
         if (cnt_q == '0) cnt_q <= half_q - 1'b1;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign tick = run && (cnt_q == '0);

   AST_CNT_BELOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < half_q); // R1
   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && half_q != 1) |=> !tick); // R1

endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter #(
   parameter int FRAME_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               preset,
   input  logic               lsbf_in,
   input  logic [FRAME_W-1:0] tx_in,
   input  logic               drive,
   input  logic               sample,
   input  logic               finish,
   input  logic               lsbf_q,
   input  logic               miso,
   output logic               mosi,
   output logic [FRAME_W-1:0] rx_data
);

   logic [FRAME_W-1:0] tx_q;
   logic [FRAME_W-1:0] rx_q;
   logic [FRAME_W-1:0] rx_out_q;
   logic               mosi_q;
   logic [FRAME_W-1:0] tx_rev;
   logic [FRAME_W-1:0] rx_rev;
   logic [FRAME_W-1:0] tx_ord;

   // Bit-order views: the shifter always works MSB-out, MSB-in on a
   // possibly mirrored copy of the word.
   for (genvar i = 0; i < FRAME_W; i++) begin : g_mirror
      assign tx_rev[i] = tx_in[FRAME_W-1-i];
      assign rx_rev[i] = rx_q[FRAME_W-1-i];
   end

   assign tx_ord = lsbf_in ? tx_rev : tx_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q     <= '0;
         rx_q     <= '0;
         rx_out_q <= '0;
         mosi_q   <= 1'b0;
      end else if (load) begin
         rx_q <= '0;
         if (preset) begin
            mosi_q <= tx_ord[FRAME_W-1];
            tx_q   <= {tx_ord[FRAME_W-2:0], 1'b0};
         end else begin
            tx_q   <= tx_ord;
         end
      end else begin
         if (drive) begin
            mosi_q <= tx_q[FRAME_W-1];
            tx_q   <= {tx_q[FRAME_W-2:0], 1'b0};
         end
         if (sample) rx_q <= {rx_q[FRAME_W-2:0], miso};
         if (finish) rx_out_q <= lsbf_q ? rx_rev : rx_q;
      end
   end

   assign mosi    = mosi_q;
   assign rx_data = rx_out_q;

   AST_MOSI_ONLY_ON_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mosi_q) |-> $past(drive || (load && preset))); // R4
   AST_DRIVE_SAMPLE_APART: assert property (@(posedge clk) disable iff (!rst_n)
      !(drive && sample)); // R5

endmodule

// File: rtl/spi_eng_seq.sv
module spi_eng_seq
   import spi_eng_pkg::*;
#(
   parameter  int FRAME_W  = 8,
   parameter  int HALF_W   = 11,
   parameter  int MAX_HALF = 1024,
   localparam int DIV_W    = HALF_W + 1,
   localparam int EDGES    = 2 * FRAME_W,
   localparam int EDGE_W   = $clog2(EDGES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              lsbf,
   input  logic [DIV_W-1:0]  div,
   input  logic              tick,
   output logic              load,
   output logic              preset,
   output logic [HALF_W-1:0] half_ld,
   output logic              run,
   output logic              drive,
   output logic              sample,
   output logic              finish,
   output logic              lsbf_q,
   output logic              sck,
   output logic              ss_n,
   output logic              busy,
   output logic              done
);

   localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

   spi_phase_e        state;
   logic [EDGE_W-1:0] ecnt_q;
   logic              cpol_q, cpha_q;
   logic              sck_q, ss_n_q, done_q;
   logic [HALF_W:0]   half_wide;
   logic              accept, edge_now, lead_edge;

   // Round an odd divider up, then clamp to the legal half-period range.
   assign half_wide = {1'b0, div[DIV_W-1:1]} + {{HALF_W{1'b0}}, div[0]};

   always_comb begin
      if (half_wide == '0)
         half_ld = {{(HALF_W-1){1'b0}}, 1'b1};
      else if (half_wide > (HALF_W+1)'(MAX_HALF))
         half_ld = HALF_W'(MAX_HALF);
      else
         half_ld = half_wide[HALF_W-1:0];
   end

   assign accept    = start && (state == PH_IDLE);
   assign load      = accept;
   assign preset    = accept && !cpha;
   assign run       = (state != PH_IDLE);
   assign edge_now  = tick && (state == PH_LEAD || state == PH_XFER);
   assign lead_edge = ~ecnt_q[0];
   assign sample    = edge_now && (cpha_q ? ~lead_edge : lead_edge);
   assign drive     = edge_now && (cpha_q ? lead_edge
                                          : (~lead_edge && ecnt_q != LAST_EDGE));
   assign finish    = tick && (state == PH_LAG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= PH_IDLE;
         ecnt_q <= '0;
         cpol_q <= 1'b0;
         cpha_q <= 1'b0;
         lsbf_q <= 1'b0;
         sck_q  <= 1'b0;
         ss_n_q <= 1'b1;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            PH_IDLE: begin
               sck_q <= cpol;
               if (accept) begin
                  cpol_q <= cpol;
                  cpha_q <= cpha;
                  lsbf_q <= lsbf;
                  ecnt_q <= '0;
                  ss_n_q <= 1'b0;
                  state  <= PH_LEAD;
               end
            end
            PH_LEAD, PH_XFER: begin
               if (tick) begin
                  sck_q <= ~sck_q;
                  if (ecnt_q == LAST_EDGE) begin
                     state <= PH_LAG;
                  end else begin
                     ecnt_q <= ecnt_q + 1'b1;
                     state  <= PH_XFER;
                  end
               end
            end
            PH_LAG: begin
               if (tick) begin
                  ss_n_q <= 1'b1;
                  done_q <= 1'b1;
                  state  <= PH_IDLE;
               end
            end
            default: state <= PH_IDLE;
         endcase
      end
   end

   assign sck  = sck_q;
   assign ss_n = ss_n_q;
   assign busy = run;
   assign done = done_q;

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R7
   AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (ss_n_q && !busy)); // R7
   AST_SCK_HOME_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ss_n_q) |-> (sck_q == cpol_q)); // R2
   AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (start && state != PH_IDLE) |=> ($stable(cpol_q) && $stable(cpha_q) && $stable(lsbf_q))); // R9

endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine #(
   parameter  int FRAME_W    = 8,
   parameter  int MAX_PERIOD = 2048,
   localparam int MAX_HALF   = MAX_PERIOD / 2,
   localparam int HALF_W     = $clog2(MAX_HALF + 1),
   localparam int DIV_W      = HALF_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] tx_data,
   input  logic [DIV_W-1:0]   div,
   input  logic               cpol,
   input  logic               cpha,
   input  logic               lsbf,
   input  logic               miso,
   output logic               sck,
   output logic               mosi,
   output logic               ss_n,
   output logic [FRAME_W-1:0] rx_data,
   output logic               busy,
   output logic               done
);

   if (FRAME_W < 2) begin : g_bad_frame
      $error("FRAME_W must be at least 2");
   end
   if (MAX_PERIOD < 2 || (MAX_PERIOD % 2) != 0) begin : g_bad_period
      $error("MAX_PERIOD must be even and at least 2");
   end

   logic              load, preset, run, tick;
   logic              drive, sample, finish, lsbf_q;
   logic [HALF_W-1:0] half_ld;

   spi_eng_seq #(
      .FRAME_W  (FRAME_W),
      .HALF_W   (HALF_W),
      .MAX_HALF (MAX_HALF)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .cpol    (cpol),
      .cpha    (cpha),
      .lsbf    (lsbf),
      .div     (div),
      .tick    (tick),
      .load    (load),
      .preset  (preset),
      .half_ld (half_ld),
      .run     (run),
      .drive   (drive),
      .sample  (sample),
      .finish  (finish),
      .lsbf_q  (lsbf_q),
      .sck     (sck),
      .ss_n    (ss_n),
      .busy    (busy),
      .done    (done)
   );

   spi_eng_divider #(
      .HALF_W (HALF_W)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .half_in (half_ld),
      .run     (run),
      .tick    (tick)
   );

   spi_eng_shifter #(
      .FRAME_W (FRAME_W)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .preset  (preset),
      .lsbf_in (lsbf),
      .tx_in   (tx_data),
      .drive   (drive),
      .sample  (sample),
      .finish  (finish),
      .lsbf_q  (lsbf_q),
      .miso    (miso),
      .mosi    (mosi),
      .rx_data (rx_data)
   );

endmodule

// File: tb/spi_master_engine_bench.sv
`timescale 1ns/1ps
module spi_master_engine_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic [11:0] div = 12'd4;
   logic       cpol = 1'b0, cpha = 1'b0, lsbf = 1'b0;
   logic       miso = 1'b0;
   logic       sck, mosi, ss_n, busy, done;
   logic [7:0] rx_data;

   spi_master_engine u_spi_master_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .tx_data(tx_data), .div(div),
      .cpol(cpol), .cpha(cpha), .lsbf(lsbf), .miso(miso), .sck(sck),
      .mosi(mosi), .ss_n(ss_n), .rx_data(rx_data), .busy(busy), .done(done)
   );

   always #2 clk = ~clk;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int half_of(input int dv);
      int h;
      h = (dv + 1) / 2;
      if (h < 1)    h = 1;
      if (h > 1024) h = 1024;
      return h;
   endfunction

   function automatic bit bit_at(input logic [7:0] d, input bit lsb, input int k);
      return lsb ? d[k] : d[7-k];
   endfunction

   // Expected frame configuration, fixed at each accepted start
   logic [7:0] exp_tx = 8'h00, exp_sd = 8'h00;
   bit  exp_cpol = 0, exp_cpha = 0, exp_lsbf = 0;
   int  exp_h = 1;

   // Behavioural slave: drives MISO and captures MOSI on the bench's own edge rules
   int  s_edge = 0, s_idx = 0, s_samp = 0;
   logic [7:0] s_cap = 8'h00;
   logic s_prev_ss = 1'b1;

   always @(ss_n or sck) begin
      if (ss_n !== s_prev_ss) begin
         s_prev_ss = ss_n;
         if (ss_n === 1'b0) begin
            s_edge = 0; s_idx = 0; s_samp = 0; s_cap = 8'h00;
            if (!exp_cpha) miso = bit_at(exp_sd, exp_lsbf, 0);
         end
      end else if (ss_n === 1'b0) begin
         bit lead_e;
         lead_e = (s_edge % 2) == 0;
         if (lead_e != exp_cpha) begin
            if (s_samp < 8) begin
               if (exp_lsbf) s_cap[s_samp] = mosi;
               else          s_cap[7-s_samp] = mosi;
            end
            s_samp++;
         end else if (exp_cpha) begin
            if (s_idx < 8) miso = bit_at(exp_sd, exp_lsbf, s_idx);
            s_idx++;
         end else begin
            s_idx++;
            if (s_idx < 8) miso = bit_at(exp_sd, exp_lsbf, s_idx);
         end
         s_edge++;
      end
   end

   // Interval monitor: length of every constant-SCK stretch while selected
   logic m_prev_ss = 1'b1;
   logic m_prev_sck = 1'b0;
   int seg = 0, seg_idx = 0, m_edges = 0, bad_r1 = 0;
   int lead_len = 0, lag_len = 0;
   logic rel_sck = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (ss_n == 1'b0) begin
            if (m_prev_ss) begin
               seg = 1; seg_idx = 0; m_edges = 0; bad_r1 = 0; m_prev_sck = sck;
            end else if (sck !== m_prev_sck) begin
               if (seg_idx == 0) lead_len = seg;
               else if (seg != exp_h) bad_r1++;
               seg_idx++; m_edges++; seg = 1; m_prev_sck = sck;
            end else begin
               seg++;
            end
         end else if (!m_prev_ss) begin
            lag_len = seg;
            rel_sck = sck;
         end
         m_prev_ss = ss_n;
      end
   end

   // mode: 0 plain, 1 change inputs mid-frame, 2 strobe mid-frame,
   //       3 strobe in last busy cycle, 4 strobe in done cycle (chain)
   task automatic frame(input logic [7:0] tx, input logic [7:0] sd, input int dv,
                        input bit pol, input bit pha, input bit lsb,
                        input int mode, input bit chained);
      int busy_cnt;
      int guard;
      string tag;
      tag = lsb ? "R6" : (pha ? "R5" : "R4");
      if (!chained) begin
         @(negedge clk);
         tx_data = tx; div = dv[11:0]; cpol = pol; cpha = pha; lsbf = lsb;
         exp_tx = tx; exp_sd = sd; exp_cpol = pol; exp_cpha = pha;
         exp_lsbf = lsb; exp_h = half_of(dv);
         repeat (2) @(negedge clk);
         check(sck == pol && ss_n == 1'b1, "R2", "idle sck level", sck, pol);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end else begin
         @(negedge clk);
         start = 1'b0;
      end
      check(busy == 1'b1 && ss_n == 1'b0, "R7", "busy and select after start",
            {busy, ss_n}, 2);
      if (!pha)
         check(mosi == bit_at(tx, lsb, 0), "R4", "first bit present at select",
               mosi, bit_at(tx, lsb, 0));
      busy_cnt = 1;
      guard = 0;
      while (!done && guard < 40000) begin
         if (mode == 1 && busy_cnt == 3) begin
            tx_data = ~tx; div = 12'd6; cpol = ~pol; cpha = ~pha; lsbf = ~lsb;
         end
         if (mode == 2 && busy_cnt == 5) begin
            tx_data = ~tx; start = 1'b1;
         end
         if (mode == 2 && busy_cnt == 6) start = 1'b0;
         if (mode == 3 && busy_cnt == 17 * exp_h) start = 1'b1;
         @(negedge clk);
         guard++;
         if (busy) busy_cnt++;
      end
      #1;
      check(done == 1'b1, "R7", "done seen", done, 1);
      check(ss_n == 1'b1 && busy == 1'b0, "R7", "done with select released",
            {ss_n, busy}, 2);
      check(busy_cnt == 17 * exp_h, "R7", "busy length", busy_cnt, 17 * exp_h);
      check(rx_data == sd, tag, "received byte", rx_data, sd);
      check(s_cap == tx, tag, "sent byte", s_cap, tx);
      check(bad_r1 == 0, "R1", "sck high/low stretches off length", bad_r1, 0);
      check(lead_len == exp_h, "R3", "lead interval", lead_len, exp_h);
      check(lag_len == exp_h, "R3", "lag interval", lag_len, exp_h);
      check(m_edges == 16, "R2", "sck transitions", m_edges, 16);
      check(rel_sck == exp_cpol, "R2", "sck at release", rel_sck, exp_cpol);
      if (mode == 1)
         check(rx_data == sd && s_cap == tx && busy_cnt == 17 * exp_h, "R9",
               "frame unchanged by mid-frame inputs", s_cap, tx);
      if (mode == 2)
         check(s_cap == tx && busy_cnt == 17 * exp_h, "R8",
               "mid-frame strobe ignored", s_cap, tx);
      if (mode == 4) begin
         start = 1'b1;
      end else begin
         start = 1'b0;
         @(negedge clk);
         check(done == 1'b0, "R7", "done lasts one cycle", done, 0);
         if (mode == 3)
            check(busy == 1'b0 && ss_n == 1'b1, "R8",
                  "strobe in last busy cycle ignored", busy, 0);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL R7 watchdog expired actual=running expected=idle");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'h5EED_0042);
      repeat (4) @(negedge clk);
      check(ss_n == 1'b1, "R10", "reset ss_n", ss_n, 1);
      check(busy == 1'b0, "R10", "reset busy", busy, 0);
      check(done == 1'b0, "R10", "reset done", done, 0);
      check(sck == 1'b0, "R10", "reset sck", sck, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // Directed: all four polarity/phase pairs, both orders, divider edges
      frame(8'hA5, 8'h3C, 4,    0, 0, 0, 0, 0);
      frame(8'h96, 8'hE1, 4,    0, 1, 0, 0, 0);
      frame(8'h5A, 8'h81, 6,    1, 0, 0, 0, 0);
      frame(8'hC3, 8'h7E, 6,    1, 1, 0, 0, 0);
      frame(8'h01, 8'h80, 2,    0, 0, 1, 0, 0);
      frame(8'hF0, 8'h0F, 3,    1, 1, 1, 0, 0);
      frame(8'h6B, 8'hD4, 0,    0, 1, 1, 0, 0);
      frame(8'h3E, 8'hA7, 2048, 0, 0, 0, 0, 0);
      frame(8'hB9, 8'h52, 4095, 1, 0, 1, 0, 0);
      // Latching, ignored strobes and the strobe-at-completion race
      frame(8'h24, 8'hDB, 8,    0, 1, 0, 1, 0);
      frame(8'h71, 8'h8E, 10,   1, 0, 1, 2, 0);
      frame(8'hCA, 8'h35, 4,    0, 0, 0, 3, 0);
      frame(8'h5C, 8'hA3, 4,    1, 1, 0, 4, 0);
      frame(8'h5C, 8'hA3, 4,    1, 1, 0, 0, 1);

      // Constrained random frames
      for (int i = 0; i < 20; i++) begin
         logic [7:0] t, s;
         int d;
         t = 8'($urandom);
         s = 8'($urandom);
         d = 2 + int'($urandom % 40);
         frame(t, s, d, 1'($urandom), 1'($urandom), 1'($urandom), 0, 0);
      end

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule